// File: doc/BRIEF.md
# GPIO Bank with Shared Blink Generators

This block is a bank of general-purpose output lines (up to 32, set by a parameter). Any output line can be told to toggle by itself instead of holding a fixed level. The toggling comes from two blink generators, set A and set B. Every line of the bank shares them. Each generator runs a free-running high/low waveform from the core clock. The high time and the low time are each held in their own register, counted in clock cycles.

Every line has four configuration bits: a static output level, a direction bit, a blink enable and a generator select. The pad mux registers the result, so the pad output and the pad output-enable change one clock after the state that drives them. A simple word-addressed write/read port reaches all eight registers. Read data is registered and valid one clock after the address is presented.

Top module: `gpio_blink_bank`

## Requirements
- R1: Synchronous reset clears the output-level, direction, blink-enable and select registers to 0. It sets all four duration registers to 1. Both pad vectors are 0 after reset.
- R2: Register addresses on `reg_addr` are: 0 output level, 1 direction, 2 blink enable, 3 generator select, 4 set A high time, 5 set A low time, 6 set B high time, 7 set B low time. A write with `reg_we` high updates the register at the clock edge. `reg_rdata` shows the zero-extended value of the addressed register one clock after the address is applied. A duration register reads back the raw written value, 0 included.
- R3: A line with direction bit 1 and blink enable 0 drives its output-level bit on `pad_out`. `pad_oe` equals the direction register. Both are registered, one clock behind the configuration.
- R4: A line with direction bit 0 has `pad_oe` 0 and `pad_out` 0, whatever its blink enable and output level are.
- R5: With blink enabled, an output line carries its generator's waveform and ignores its output-level bit.
- R6: A generator holds its waveform high for the high-time value in cycles, then low for the low-time value in cycles, and repeats.
- R7: Select bit 0 takes set A and select bit 1 takes set B. The two sets run independently.
- R8: A duration value of 0 behaves as 1 cycle.
- R9: A new duration value is taken only at a phase boundary. A phase already running keeps the length it started with.
- R10: After reset, both generators run one cycle high and one cycle low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also the blink time base |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| pad_out | output | NLINES | Pad output level per line |
| pad_oe | output | NLINES | Pad output enable per line |

## Verification
A duration write can land in the same cycle as a running phase of the generator it configures. The bench provokes this by waiting for a rising edge on a blinking pad, then rewriting that generator's high time two cycles later. It judges the result from measured pad run lengths. The high run already in progress must keep its old length, and the next high run must carry the new length. The blink enable and the static output level also meet on one line at the same time. The bench checks that the waveform wins while the blink enable is set, and that the static level comes back once it is cleared.

// File: rtl/gpio_blink_pkg.sv
package gpio_blink_pkg;
  typedef enum logic [2:0] {
    RA_OUT   = 3'd0,
    RA_DIR   = 3'd1,
    RA_BLINK = 3'd2,
    RA_SEL   = 3'd3,
    RA_A_ON  = 3'd4,
    RA_A_OFF = 3'd5,
    RA_B_ON  = 3'd6,
    RA_B_OFF = 3'd7
  } reg_addr_e;

  localparam int unsigned NUM_SETS = 2;
endpackage

// File: rtl/gpio_blink_regs.sv
module gpio_blink_regs
  import gpio_blink_pkg::*;
#(
  parameter int unsigned NLINES = 8,
  parameter int unsigned DUR_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic [2:0]                       addr,
  input  logic [DATA_W-1:0]                wdata,
  output logic [DATA_W-1:0]                rdata,
  output logic [NLINES-1:0]                out_q,
  output logic [NLINES-1:0]                dir_q,
  output logic [NLINES-1:0]                blink_q,
  output logic [NLINES-1:0]                sel_q,
  output logic [NUM_SETS-1:0][DUR_W-1:0]   on_q,
  output logic [NUM_SETS-1:0][DUR_W-1:0]   off_q
);
  localparam logic [DUR_W-1:0] DUR_ONE = DUR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      dir_q   <= '0;
      blink_q <= '0;
      sel_q   <= '0;
      on_q    <= {NUM_SETS{DUR_ONE}};
      off_q   <= {NUM_SETS{DUR_ONE}};
    end else if (we) begin
      case (reg_addr_e'(addr))
        RA_OUT:   out_q    <= wdata[NLINES-1:0];
        RA_DIR:   dir_q    <= wdata[NLINES-1:0];
        RA_BLINK: blink_q  <= wdata[NLINES-1:0];
        RA_SEL:   sel_q    <= wdata[NLINES-1:0];
        RA_A_ON:  on_q[0]  <= wdata[DUR_W-1:0];
        RA_A_OFF: off_q[0] <= wdata[DUR_W-1:0];
        RA_B_ON:  on_q[1]  <= wdata[DUR_W-1:0];
        RA_B_OFF: off_q[1] <= wdata[DUR_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (reg_addr_e'(addr))
        RA_OUT:   rdata <= DATA_W'(out_q);
        RA_DIR:   rdata <= DATA_W'(dir_q);
        RA_BLINK: rdata <= DATA_W'(blink_q);
        RA_SEL:   rdata <= DATA_W'(sel_q);
        RA_A_ON:  rdata <= DATA_W'(on_q[0]);
        RA_A_OFF: rdata <= DATA_W'(off_q[0]);
        RA_B_ON:  rdata <= DATA_W'(on_q[1]);
        RA_B_OFF: rdata <= DATA_W'(off_q[1]);
        default:  rdata <= '0;
      endcase
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (out_q == '0 && dir_q == '0 && blink_q == '0 && sel_q == '0
                    && on_q[0] == DUR_ONE && off_q[1] == DUR_ONE));
endmodule

// File: rtl/gpio_blink_timer.sv
module gpio_blink_timer #(
  parameter int unsigned DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DUR_W-1:0] cfg_on,
  input  logic [DUR_W-1:0] cfg_off,
  output logic             wave
);
  localparam logic [DUR_W-1:0] DUR_ONE = DUR_W'(1);

  logic [DUR_W-1:0] sh_on, sh_off, cnt, len;
  logic             phase, last;

  function automatic logic [DUR_W-1:0] at_least_one(input logic [DUR_W-1:0] v);
    return (v == '0) ? DUR_ONE : v;
  endfunction

  assign len  = phase ? sh_on : sh_off;
  assign last = (cnt == len - DUR_ONE);
  assign wave = phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= 1'b1;
      cnt    <= '0;
      sh_on  <= DUR_ONE;
      sh_off <= DUR_ONE;
    end else if (last) begin
      phase  <= ~phase;
      cnt    <= '0;
      sh_on  <= at_least_one(cfg_on);
      sh_off <= at_least_one(cfg_off);
    end else begin
      cnt <= cnt + DUR_ONE;
    end
  end

  // R8
  dur_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (sh_on != '0) && (sh_off != '0));
  // R9
  mid_phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !last |=> $stable(sh_on) && $stable(sh_off) && $stable(phase));
  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < len);
endmodule

// File: rtl/gpio_blink_padmux.sv
module gpio_blink_padmux
  import gpio_blink_pkg::*;
#(
  parameter int unsigned NLINES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NLINES-1:0]   out_q,
  input  logic [NLINES-1:0]   dir_q,
  input  logic [NLINES-1:0]   blink_q,
  input  logic [NLINES-1:0]   sel_q,
  input  logic [NUM_SETS-1:0] wave,
  output logic [NLINES-1:0]   pad_out,
  output logic [NLINES-1:0]   pad_oe
);
  logic [NLINES-1:0] level;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    assign level[i] = dir_q[i] & (blink_q[i] ? wave[sel_q[i]] : out_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= level;
      pad_oe  <= dir_q;
    end
  end

  // R4
  input_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pad_out | pad_oe) & ~$past(dir_q)) == '0));
  // R3
  static_drive_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pad_out ^ $past(out_q)) & $past(dir_q & ~blink_q)) == '0));
endmodule

// File: rtl/gpio_blink_bank.sv
module gpio_blink_bank
  import gpio_blink_pkg::*;
#(
  parameter int unsigned NLINES = 8,
  parameter int unsigned DUR_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe
);
  logic [NLINES-1:0]               out_q, dir_q, blink_q, sel_q;
  logic [NUM_SETS-1:0][DUR_W-1:0]  on_q, off_q;
  logic [NUM_SETS-1:0]             wave;

  gpio_blink_regs #(.NLINES(NLINES), .DUR_W(DUR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .out_q(out_q), .dir_q(dir_q), .blink_q(blink_q),
    .sel_q(sel_q), .on_q(on_q), .off_q(off_q)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    gpio_blink_timer #(.DUR_W(DUR_W)) u_timer (
      .clk(clk), .rst(rst), .cfg_on(on_q[s]), .cfg_off(off_q[s]), .wave(wave[s])
    );
  end

  gpio_blink_padmux #(.NLINES(NLINES)) u_pad (
    .clk(clk), .rst(rst), .out_q(out_q), .dir_q(dir_q), .blink_q(blink_q),
    .sel_q(sel_q), .wave(wave), .pad_out(pad_out), .pad_oe(pad_oe)
  );
endmodule

// File: tb/gpio_blink_bank_bench.sv
`timescale 1ns/1ps
module gpio_blink_bank_bench;
  localparam int NLINES = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_we = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [NLINES-1:0] pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  gpio_blink_bank #(.NLINES(NLINES), .DUR_W(16), .DATA_W(DATA_W)) u_gpio_blink_bank (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #2 clk = ~clk;

  // run-length monitor on lines 0 and 1
  int hi_len[2], lo_len[2], nrun[2], run[2];
  logic prev[2];
  initial begin
    for (int k = 0; k < 2; k++) begin
      hi_len[k] = 0; lo_len[k] = 0; nrun[k] = 0; run[k] = 0; prev[k] = 1'b0;
    end
  end
  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (pad_out[k] === prev[k]) run[k]++;
      else begin
        if (prev[k]) hi_len[k] = run[k]; else lo_len[k] = run[k];
        nrun[k]++;
        prev[k] = pad_out[k];
        run[k] = 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    tick();
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = DATA_W'(d);
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    tick();
    reg_addr = 3'(a);
    tick();
    d = int'(reg_rdata);
  endtask

  task automatic wait_runs(int l, int n);
    int start = nrun[l];
    for (int g = 0; g < 2000 && nrun[l] < start + n; g++) tick();
  endtask

  task automatic wait_pad(int l, logic v);
    for (int g = 0; g < 2000 && pad_out[l] !== v; g++) tick();
  endtask

  // {dir, out, expected pad_out}; blink disabled, pad_oe expected = dir
  localparam logic [23:0] VEC [4] = '{
    {8'hFF, 8'hA5, 8'hA5},
    {8'h0F, 8'hFF, 8'h0F},
    {8'h00, 8'hFF, 8'h00},
    {8'hF0, 8'h3C, 8'h30}
  };

  initial begin
    int d;
    int ones, zeros;
    repeat (5) tick();
    chk("R1 pad_out", int'(pad_out), 0);
    chk("R1 pad_oe", int'(pad_oe), 0);
    rst = 1'b0;
    tick();
    // R1 R2 reset readback
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      chk(a < 4 ? "R1 reg zero" : "R1 duration one", d, a < 4 ? 0 : 1);
    end

    // R3 R4 static table
    for (int i = 0; i < 4; i++) begin
      wr(1, int'(VEC[i][23:16]));
      wr(0, int'(VEC[i][15:8]));
      tick(); tick();
      chk("R3 R4 pad_out", int'(pad_out), int'(VEC[i][7:0]));
      chk("R3 pad_oe", int'(pad_oe), int'(VEC[i][23:16]));
    end

    // R10 default waveform, both sets
    wr(0, 0); wr(1, 8'hFF); wr(3, 8'h02); wr(2, 8'h03);
    wait_runs(0, 5); wait_runs(1, 5);
    chk("R10 A high", hi_len[0], 1); chk("R10 A low", lo_len[0], 1);
    chk("R10 B high", hi_len[1], 1); chk("R10 B low", lo_len[1], 1);

    // R6 R7 independent sets
    wr(4, 3); wr(5, 5); wr(6, 2); wr(7, 4);
    wait_runs(0, 6); wait_runs(1, 6);
    chk("R6 A high", hi_len[0], 3); chk("R6 A low", lo_len[0], 5);
    chk("R7 B high", hi_len[1], 2); chk("R7 B low", lo_len[1], 4);
    rd(4, d); chk("R2 A_on readback", d, 3);

    // R8 zero duration
    wr(6, 0); wr(7, 0);
    wait_runs(1, 6);
    chk("R8 B high", hi_len[1], 1); chk("R8 B low", lo_len[1], 1);
    rd(6, d); chk("R2 raw zero readback", d, 0);

    // R9 write mid-phase
    wr(4, 6); wr(5, 6);
    wait_runs(0, 6);
    wait_pad(0, 1'b0); wait_pad(0, 1'b1);
    tick(); tick();
    wr(4, 2);
    wait_pad(0, 1'b0); tick();
    chk("R9 running high kept", hi_len[0], 6);
    wait_runs(0, 2);
    chk("R9 next high new", hi_len[0], 2);
    chk("R9 low unchanged", lo_len[0], 6);

    // R5 blink wins over output level
    wr(0, 8'h01);
    ones = 0; zeros = 0;
    for (int c = 0; c < 24; c++) begin
      tick();
      if (pad_out[0]) ones++; else zeros++;
    end
    chk("R5 waveform low seen", int'(zeros > 0), 1);
    chk("R5 waveform high seen", int'(ones > 0), 1);
    wr(2, 8'h02);
    tick(); tick();
    chk("R3 static back", int'(pad_out[0]), 1);

    // R4 input line with blink enabled
    wr(1, 8'hFD);
    ones = 0;
    for (int c = 0; c < 12; c++) begin
      tick();
      if (pad_out[1] || pad_oe[1]) ones++;
    end
    chk("R4 input line quiet", ones, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule